// File: doc/BRIEF.md
# Divergence-Bounded State Update Aggregator

This block sits between a counter array in the forwarding path and the narrow link that carries counter snapshots to a controller. Each incoming update names a counter location and gives its new value. The block keeps a small direct-mapped table. Each entry records which location it holds, the newest value seen for that location, and the value the controller was last sent. Repeated updates to one location overwrite the newest value in place. A message goes out only when the newest value has drifted from the controller's copy by more than a runtime threshold. Many updates therefore collapse into one export, and the controller's copy never lags by more than the threshold.

When an update maps to a slot held by another location, the resident location is flushed to the controller first if its copy is stale. The slot is then taken over, and the newcomer is treated as if the controller held zero for it. Exports leave on a valid/ready stream. When that stream stalls, the block withholds acceptance of further updates rather than lose a message.

Top module: `div_bound_aggregator`

## Requirements
- R1: After reset every slot holds location 0 with newest and last-sent values 0; `exp_valid` is low and `upd_ready` is high.
- R2: The slot index is the XOR fold of the location, bit i of the location feeding index bit (i mod 4) for 16 slots; updates to a resident location overwrite its newest value and merge into one entry.
- R3: An accepted update whose gap |new value − last-sent value| is less than or equal to `threshold` produces no export.
- R4: An accepted update whose gap exceeds `threshold` exports (location, new value); with nothing pending, `exp_valid` is high in the cycle after acceptance, and the slot's last-sent value becomes the new value.
- R5: An update to a location other than the slot's resident exports the resident's (location, newest value) when its newest and last-sent values differ. Otherwise the resident is dropped silently. The newcomer then starts with a last-sent value of 0.
- R6: Exports leave in acceptance order, and an eviction export precedes the export of the update that caused it.
- R7: `upd_ready` is high only when no export is pending, or exactly one is pending and `exp_ready` is high. While `exp_valid` is high and `exp_ready` is low, `exp_loc` and `exp_val` hold steady, and no export is ever lost.
- R8: `threshold` is sampled with each accepted update, so a change applies from the next accepted update.
- R9: Cycles with `upd_valid` low leave the table and the export stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_valid | input | 1 | Update offered |
| upd_ready | output | 1 | Update accepted this cycle when high with `upd_valid` |
| upd_loc | input | LOC_W | Counter location of the update |
| upd_val | input | VAL_W | New counter value |
| threshold | input | VAL_W | Largest divergence tolerated without an export |
| exp_valid | output | 1 | Export message present |
| exp_ready | input | 1 | Link takes the export this cycle |
| exp_loc | output | LOC_W | Location of the exported counter |
| exp_val | output | VAL_W | Exported value |

## Verification
Two events can fall in the same accepted update: the eviction of a stale resident and a threshold-exceeding export for the newcomer. Both messages are then queued in one cycle. The bench provokes this by aliasing two locations onto one slot, with the resident left stale and the newcomer's value well above the threshold. It also provokes it repeatedly in a sweep over many aliasing locations while `exp_ready` toggles. A reference model computed in the bench judges each handshake, and ordering is checked message by message. A separate case holds `exp_ready` low to show that acceptance stops while the output holds steady.

// File: rtl/div_bound_aggregator.sv
module div_bound_aggregator #(
  parameter int LOC_W   = 8,
  parameter int VAL_W   = 32,
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [LOC_W-1:0] upd_loc,
  input  logic [VAL_W-1:0] upd_val,
  input  logic [VAL_W-1:0] threshold,
  output logic             exp_valid,
  input  logic             exp_ready,
  output logic [LOC_W-1:0] exp_loc,
  output logic [VAL_W-1:0] exp_val
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int MSG_W = LOC_W + VAL_W;

  logic [LOC_W-1:0] tag_q  [ENTRIES];
  logic [VAL_W-1:0] cur_q  [ENTRIES];
  logic [VAL_W-1:0] sent_q [ENTRIES];

  logic [1:0]       cnt_q;
  logic [MSG_W-1:0] head_q, tail_q;

  function automatic logic [IDX_W-1:0] fold(input logic [LOC_W-1:0] l);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < LOC_W; i++) r[i % IDX_W] ^= l[i];
    return r;
  endfunction

  logic [IDX_W-1:0] idx;
  logic             hit, evict, send, accept, pop;
  logic [VAL_W-1:0] base, gap;

  assign idx    = fold(upd_loc);
  assign hit    = tag_q[idx] == upd_loc;
  assign base   = hit ? sent_q[idx] : '0;
  assign gap    = (upd_val >= base) ? upd_val - base : base - upd_val;
  assign send   = gap > threshold;
  assign evict  = !hit && (cur_q[idx] != sent_q[idx]);

  assign exp_valid = cnt_q != 2'd0;
  assign pop       = exp_valid && exp_ready;
  assign upd_ready = (cnt_q == 2'd0) || (cnt_q == 2'd1 && exp_ready);
  assign accept    = upd_valid && upd_ready;
  assign {exp_loc, exp_val} = head_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e]  <= '0;
        cur_q[e]  <= '0;
        sent_q[e] <= '0;
      end
    end else if (accept) begin
      tag_q[idx]  <= upd_loc;
      cur_q[idx]  <= upd_val;
      sent_q[idx] <= send ? upd_val : base;
      cnt_q       <= 2'(evict) + 2'(send);
      head_q      <= evict ? {tag_q[idx], cur_q[idx]} : {upd_loc, upd_val};
      tail_q      <= {upd_loc, upd_val};
    end else if (pop) begin
      head_q <= tail_q;
      cnt_q  <= cnt_q - 2'd1;
    end
  end
endmodule

module div_bound_aggregator_chk #(
  parameter int LOC_W = 8,
  parameter int VAL_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic             exp_valid,
  input logic             exp_ready,
  input logic [LOC_W-1:0] exp_loc,
  input logic [VAL_W-1:0] exp_val,
  input logic             evict
);
  assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exp_valid && !exp_ready |=> exp_valid && $stable(exp_loc) && $stable(exp_val));

  assert_refuse_when_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exp_valid && !exp_ready |-> !upd_ready);

  assert_no_spontaneous_export_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_ready) && !exp_valid |=> !exp_valid);

  assert_evict_exports_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_ready && evict |=> exp_valid);
endmodule

bind div_bound_aggregator div_bound_aggregator_chk #(.LOC_W(LOC_W), .VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
  .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_loc(exp_loc),
  .exp_val(exp_val), .evict(evict)
);

// File: tb/div_bound_aggregator_test.sv
module div_bound_aggregator_test;
  logic        clk = 0, rst_n = 0;
  logic        upd_valid = 0, upd_ready, exp_valid, exp_ready = 1;
  logic [7:0]  upd_loc = 0, exp_loc;
  logic [31:0] upd_val = 0, threshold = 0, exp_val;

  div_bound_aggregator uut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0, mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  mt [16];
  logic [31:0] mv [16], ms [16];
  logic [39:0] expq [$];
  logic        obs_v, acc;
  string       cur_req = "R1";

  function automatic logic [3:0] hashb(input logic [7:0] l);
    return l[3:0] ^ l[7:4];
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic model_apply(input logic [7:0] l, input logic [31:0] d, input logic [31:0] t);
    logic [3:0] ix; logic hit; logic [31:0] b, g;
    ix = hashb(l); hit = mt[ix] == l; b = hit ? ms[ix] : 0;
    if (!hit && mv[ix] != ms[ix]) expq.push_back({mt[ix], mv[ix]});
    g = (d >= b) ? d - b : b - d;
    if (g > t) begin expq.push_back({l, d}); b = d; end
    mt[ix] = l; mv[ix] = d; ms[ix] = b;
  endtask

  task automatic observe();
    obs_v = exp_valid;
    if (exp_valid && exp_ready) begin
      if (expq.size() == 0) check(0, cur_req, {24'h0, exp_loc, exp_val}, 64'h0);
      else begin
        logic [39:0] e;
        e = expq.pop_front();
        check({exp_loc, exp_val} == e, cur_req, {24'h0, exp_loc, exp_val}, {24'h0, e});
      end
    end
  endtask

  task automatic cycle(input logic v, input logic [7:0] l, input logic [31:0] d,
                       input logic [31:0] t, output logic a);
    @(negedge clk);
    upd_valid = v; upd_loc = l; upd_val = d; threshold = t;
    if (mode == 0) exp_ready = 1;
    else if (mode == 1) begin step_lfsr(); exp_ready = lfsr[0] | lfsr[1]; end
    else exp_ready = 0;
    #1;
    observe();
    a = v && upd_ready;
    if (a) model_apply(l, d, t);
  endtask

  task automatic send(input logic [7:0] l, input logic [31:0] d, input logic [31:0] t);
    logic a;
    do cycle(1, l, d, t, a); while (!a);
  endtask

  task automatic idle();
    logic a;
    cycle(0, 8'h00, 32'h0, 32'h0, a);
  endtask

  task automatic drain(input string req);
    mode = 0;
    for (int k = 0; k < 8; k++) idle();
    check(expq.size() == 0 && !exp_valid, req, expq.size(), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int e = 0; e < 16; e++) begin mt[e] = 0; mv[e] = 0; ms[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(!exp_valid && upd_ready, "R1", {exp_valid, upd_ready}, 2'b01);

    cur_req = "R2";
    send(8'h05, 1, 1);
    idle();
    check(!obs_v, "R3", obs_v, 0);
    send(8'h05, 2, 1);
    idle();
    check(obs_v, "R4", obs_v, 1);
    drain("R2");

    cur_req = "R3";
    send(8'h09, 3, 3); idle();
    check(!obs_v, "R3", obs_v, 0);
    send(8'h09, 7, 3); idle();
    check(obs_v, "R4", obs_v, 1);
    send(8'h09, 4, 3); idle();
    check(!obs_v, "R3", obs_v, 0);
    send(8'h09, 11, 3);
    drain("R3");

    cur_req = "R5";
    send(8'h01, 4, 10);
    send(8'h10, 2, 10); idle();
    check(obs_v, "R5", obs_v, 1);
    cur_req = "R6";
    send(8'h01, 20, 10);
    drain("R6");
    cur_req = "R5";
    send(8'h10, 0, 10); idle();
    check(!obs_v, "R5", obs_v, 0);
    drain("R5");

    cur_req = "R8";
    send(8'h33, 50, 100); idle();
    check(!obs_v, "R8", obs_v, 0);
    send(8'h33, 50, 10); idle();
    check(obs_v, "R8", obs_v, 1);
    drain("R8");

    cur_req = "R9";
    for (int k = 0; k < 4; k++) begin
      cycle(0, 8'h44, 32'd900, 32'd0, acc);
      check(!obs_v, "R9", obs_v, 0);
    end
    send(8'h44, 0, 0); idle();
    check(!obs_v, "R9", obs_v, 0);
    drain("R9");

    cur_req = "R7";
    mode = 2;
    send(8'h21, 100, 0);
    cycle(1, 8'h22, 5, 0, acc);
    check(!acc, "R7", acc, 0);
    for (int k = 0; k < 3; k++) begin
      cycle(0, 8'h00, 0, 0, acc);
      check(exp_valid && exp_loc == 8'h21 && exp_val == 100, "R7",
            {exp_loc, exp_val}, {8'h21, 32'd100});
    end
    mode = 0;
    send(8'h22, 5, 0);
    drain("R7");

    cur_req = "R6";
    mode = 1;
    for (int t = 0; t < 4; t++) begin
      for (int n = 0; n < 400; n++) begin
        logic [7:0] l; logic [31:0] d;
        step_lfsr(); l = {lfsr[9:8], 2'b00, lfsr[3:0]};
        step_lfsr(); d = {29'h0, lfsr[2:0]} + ((n % 3 == 0) ? 32'd9 : 32'd0);
        send(l, d, t);
      end
    end
    drain("R6");

    summary();
    $finish;
  end
endmodule